// File: doc/BRIEF.md
# Voice-Channel Serial Frame Port

This block moves one telephony voice sample per frame across a bit-serial link. It runs entirely on the bit clock. A frame-sync pulse at the 8 kHz frame rate marks where the first bit of a word sits. Once per frame the port sends a parallel sample out of its transmit pin, most significant bit first. In the same bit slots it collects a sample from the receive pin and presents it as a parallel word with a one-cycle valid strobe.

Static inputs pick the sync style and the word size. In long-frame style the word starts at the rising bit-clock edge where the sync level is first seen high. In short-frame style a one-bit-wide sync pulse is caught on a falling edge, and the word starts at the rising edge that follows. Words are either 8-bit companded codes or 14-bit two's-complement linear samples. Transmit and receive can each be switched off, and a power-down input parks the transmit line high. The port does no coding arithmetic. It only serializes and deserializes aligned words.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst_n` is low, `tx_sd` is 0, `rx_valid` is 0, `rx_word` is 0 and `rx_sign` is 0.
- R2: With `short_frame` = 0 (long-frame style), a word starts at the rising `bclk` edge where `fsync` is sampled high after being low at the previous rising edge. The MSB appears on `tx_sd` after that edge. A sync pulse that is high only around a falling edge, and never at a rising edge, starts nothing.
- R3: With `short_frame` = 1, `fsync` is sampled on falling edges. A low-to-high change between two falling-edge samples starts a word at the next rising edge, with the MSB on `tx_sd` after it. A sync held for several cycles starts only one word.
- R4: With `linear_mode` = 0 the word is 8 bits, taken from `tx_word[7:0]`. Bit 7 goes out first and bit 0 last, one bit per rising edge.
- R5: With `linear_mode` = 1 the word is 14 bits, taken from `tx_word[13:0]`. Bit 13 goes out first and bit 0 last.
- R6: Outside the bit slots of a word, and when not powered down, `tx_sd` is 0.
- R7: While `pwr_down` is 1 (sampled at a rising edge), `tx_sd` is 1 after that edge. No word is started or continued, and `rx_valid` stays 0.
- R8: With `tx_off` = 1 at a rising edge, `tx_sd` is 0 after that edge. Frame timing and the received word are unaffected.
- R9: During each slot, `rx_sd` is sampled on the falling edge, MSB first. At the rising edge after the LSB is captured, `rx_valid` is 1 for one cycle and `rx_word` holds the word. In 8-bit mode the word sits in `rx_word[7:0]` with bits 13:8 zero. `rx_word` changes only with `rx_valid`.
- R10: With `rx_off` = 1 at the rising edge where a word would be delivered, no `rx_valid` pulse occurs and `rx_word` keeps its previous value.
- R11: `rx_sign` equals the MSB of the last delivered word: bit 7 in 8-bit mode, bit 13 in 14-bit mode.
- R12: `tx_word` and `linear_mode` are latched at the start of each word. Changing them while the word is shifting does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; transmit changes on rising edges, receive sampled on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse marking the first bit of each word |
| rx_sd | input | 1 | Serial receive data |
| short_frame | input | 1 | 0 = long-frame sync style, 1 = short-frame sync style |
| linear_mode | input | 1 | 0 = 8-bit companded word, 1 = 14-bit linear word |
| tx_off | input | 1 | 1 = keep the transmit line low instead of sending the sample |
| rx_off | input | 1 | 1 = discard received samples |
| pwr_down | input | 1 | 1 = power down; transmit line held high |
| tx_word | input | 14 | Parallel transmit sample, right-aligned |
| tx_sd | output | 1 | Serial transmit data |
| rx_word | output | 14 | Last delivered received sample, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when a new received word is delivered |
| rx_sign | output | 1 | Sign (MSB) of the last delivered word |

## Verification
The bench drives a sync pulse that is high only across a falling edge in long-frame style. A port that sampled sync on the wrong edge would start a frame there, and that frame shows up on `tx_sd`. Sync pulses several cycles wide are also sent. A detector that looks at level instead of a change would restart the word each cycle and repeat the MSB. A change to `tx_word` during shifting catches a design that reads the parallel input live rather than latching it. Frames with `rx_off`, `tx_off` and power-down check three things: that discarded words leave `rx_word` alone, that frame timing survives a muted transmitter, and that the line goes high rather than idle-low. Every cycle is compared against a behavioural model, so an off-by-one in word length or valid timing shows up as a mismatch at a specific bit.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    SYNC_LONG  = 1'b0,
    SYNC_SHORT = 1'b1
  } sync_style_e;

  // Number of bits in a word for the selected coding
  function automatic int unsigned word_len(input logic linear,
                                           input int unsigned lin_w,
                                           input int unsigned cmp_w);
    return linear ? lin_w : cmp_w;
  endfunction

  // Bit carried in slot 'pos' of a word of 'len' bits, MSB in slot 0
  function automatic logic pick_bit(input logic [31:0] word,
                                    input int unsigned len,
                                    input int unsigned pos);
    logic [31:0] sh;
    sh = word >> (len - 1 - pos);
    return sh[0];
  endfunction

endpackage

// File: rtl/pcm_sync_detect.sv
module pcm_sync_detect (
  input  logic bclk,
  input  logic rst_n,
  input  logic fsync,
  input  logic short_frame,
  output logic frame_start
);
  import pcm_port_pkg::*;

  logic sync_fall_q;   // fsync seen at the last falling edge
  logic sync_fall_d;   // previous falling-edge sample, moved to rising domain
  logic sync_rise_q;   // fsync seen at the previous rising edge

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) sync_fall_q <= 1'b0;
    else        sync_fall_q <= fsync;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_fall_d <= 1'b0;
      sync_rise_q <= 1'b0;
    end else begin
      sync_fall_d <= sync_fall_q;
      sync_rise_q <= fsync;
    end
  end

  logic start_short;
  logic start_long;
  assign start_short = sync_fall_q & ~sync_fall_d;
  assign start_long  = fsync & ~sync_rise_q;

  always_comb begin
    unique case (sync_style_e'(short_frame))
      SYNC_SHORT: frame_start = start_short;
      default:    frame_start = start_long;
    endcase
  end

  // R3: a held sync never gives two starts in a row
  a_r3_start_single: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start |=> !frame_start);

endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8,
  localparam int CNT_W = $clog2(LIN_W)
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [LIN_W-1:0] tx_word,
  input  logic             linear_mode,
  input  logic             tx_off,
  input  logic             pwr_down,
  output logic             tx_sd,
  output logic             slot_on,
  output logic [CNT_W-1:0] slot_pos,
  output logic             slot_lin
);
  import pcm_port_pkg::*;

  logic [LIN_W-1:0] word_q;
  logic             lin_q;
  logic [CNT_W-1:0] pos_q;
  logic             on_q;
  logic             sd_q;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] pos_next;

  function automatic logic bit_at(input logic [LIN_W-1:0] w,
                                  input logic lin,
                                  input logic [CNT_W-1:0] p);
    return pick_bit(32'(w), word_len(lin, LIN_W, CMP_W), int'(p));
  endfunction

  assign last_idx = lin_q ? CNT_W'(LIN_W - 1) : CNT_W'(CMP_W - 1);
  assign pos_next = pos_q + 1'b1;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lin_q  <= 1'b0;
      pos_q  <= '0;
      on_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else if (pwr_down) begin
      on_q <= 1'b0;
      sd_q <= 1'b1;
    end else if (frame_start) begin
      word_q <= tx_word;
      lin_q  <= linear_mode;
      pos_q  <= '0;
      on_q   <= 1'b1;
      sd_q   <= bit_at(tx_word, linear_mode, '0) & ~tx_off;
    end else if (on_q) begin
      if (pos_q == last_idx) begin
        on_q <= 1'b0;
        sd_q <= 1'b0;
      end else begin
        pos_q <= pos_next;
        sd_q  <= bit_at(word_q, lin_q, pos_next) & ~tx_off;
      end
    end else begin
      sd_q <= 1'b0;
    end
  end

  assign tx_sd    = sd_q;
  assign slot_on  = on_q;
  assign slot_pos = pos_q;
  assign slot_lin = lin_q;

  // R7: power-down parks the line high
  a_r7_pd_drives_high: assert property (@(posedge bclk) disable iff (!rst_n)
    pwr_down |=> tx_sd);

  // R8: muted transmitter keeps the line low
  a_r8_off_keeps_low: assert property (@(posedge bclk) disable iff (!rst_n)
    (tx_off && !pwr_down) |=> !tx_sd);

  // R2: a detected start opens a slot
  a_r2_start_opens_slot: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_start && !pwr_down) |=> slot_on);

  // R6: idle line stays low
  a_r6_idle_low: assert property (@(posedge bclk) disable iff (!rst_n)
    (!slot_on && !frame_start && !pwr_down) |=> !tx_sd);

endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8,
  localparam int CNT_W = $clog2(LIN_W)
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             rx_sd,
  input  logic             slot_on,
  input  logic [CNT_W-1:0] slot_pos,
  input  logic             slot_lin,
  input  logic             rx_off,
  input  logic             pwr_down,
  output logic [LIN_W-1:0] rx_word,
  output logic             rx_valid,
  output logic             rx_sign
);
  import pcm_port_pkg::*;

  logic [LIN_W-1:0] shreg_q;
  logic             last_q;
  logic [CNT_W-1:0] last_idx;
  logic [LIN_W-1:0] assembled;
  logic             deliver;

  logic [LIN_W-1:0] word_q;
  logic             valid_q;
  logic             sign_q;

  assign last_idx = slot_lin ? CNT_W'(LIN_W - 1) : CNT_W'(CMP_W - 1);

  // Falling-edge capture
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      last_q  <= 1'b0;
    end else if (pwr_down) begin
      last_q <= 1'b0;
    end else begin
      last_q <= slot_on && (slot_pos == last_idx);
      if (slot_on) shreg_q <= {shreg_q[LIN_W-2:0], rx_sd};
    end
  end

  always_comb begin
    if (slot_lin) assembled = shreg_q;
    else          assembled = LIN_W'(shreg_q[CMP_W-1:0]);
  end

  assign deliver = last_q & ~rx_off & ~pwr_down;

  // Rising-edge delivery
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      sign_q  <= 1'b0;
    end else begin
      valid_q <= deliver;
      if (deliver) begin
        word_q <= assembled;
        sign_q <= pick_bit(32'(assembled), word_len(slot_lin, LIN_W, CMP_W), 0);
      end
    end
  end

  assign rx_word  = word_q;
  assign rx_valid = valid_q;
  assign rx_sign  = sign_q;

  // R9: strobe lasts a single cycle
  a_r9_valid_single: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9: the word only moves together with the strobe
  a_r9_word_with_valid: assert property (@(posedge bclk) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_valid);

  // R10: discarded samples never raise the strobe
  a_r10_off_no_valid: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_off |=> !rx_valid);

  // R7: nothing is delivered during power-down
  a_r7_pd_no_valid: assert property (@(posedge bclk) disable iff (!rst_n)
    pwr_down |=> !rx_valid);

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             rx_sd,
  input  logic             short_frame,
  input  logic             linear_mode,
  input  logic             tx_off,
  input  logic             rx_off,
  input  logic             pwr_down,
  input  logic [LIN_W-1:0] tx_word,
  output logic             tx_sd,
  output logic [LIN_W-1:0] rx_word,
  output logic             rx_valid,
  output logic             rx_sign
);
  localparam int CNT_W = $clog2(LIN_W);

  logic             frame_start;
  logic             slot_on;
  logic [CNT_W-1:0] slot_pos;
  logic             slot_lin;

  pcm_sync_detect u_sync (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .short_frame (short_frame),
    .frame_start (frame_start)
  );

  pcm_tx_serializer #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_tx (
    .bclk        (bclk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .tx_word     (tx_word),
    .linear_mode (linear_mode),
    .tx_off      (tx_off),
    .pwr_down    (pwr_down),
    .tx_sd       (tx_sd),
    .slot_on     (slot_on),
    .slot_pos    (slot_pos),
    .slot_lin    (slot_lin)
  );

  pcm_rx_deserializer #(.LIN_W(LIN_W), .CMP_W(CMP_W)) u_rx (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .rx_sd    (rx_sd),
    .slot_on  (slot_on),
    .slot_pos (slot_pos),
    .slot_lin (slot_lin),
    .rx_off   (rx_off),
    .pwr_down (pwr_down),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .rx_sign  (rx_sign)
  );

endmodule

// File: tb/tb_pcm_frame_port.sv
module tb_pcm_frame_port;
  localparam int LW = 14;
  localparam int CW = 8;
  localparam int FRAME = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0, rx_sd = 1'b0, short_frame = 1'b0, linear_mode = 1'b0;
  logic tx_off = 1'b0, rx_off = 1'b0, pwr_down = 1'b0;
  logic [LW-1:0] tx_word = '0;
  logic tx_sd, rx_valid, rx_sign;
  logic [LW-1:0] rx_word;

  always #4 clk = ~clk;

  pcm_frame_port dut (
    .bclk(clk), .rst_n(rst_n), .fsync(fsync), .rx_sd(rx_sd),
    .short_frame(short_frame), .linear_mode(linear_mode),
    .tx_off(tx_off), .rx_off(rx_off), .pwr_down(pwr_down),
    .tx_word(tx_word), .tx_sd(tx_sd), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_sign(rx_sign)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  bit m_active = 0;
  int m_pos = 0, m_len = 8;
  int m_lat = 0;
  bit m_prev_rise = 0, m_prev_fall = 0, m_cur_fall = 0;
  bit m_pend = 0;
  int m_pend_word = 0, m_pend_len = 8;
  int exp_word = 0;
  bit exp_sign = 0;
  int rx_send = 0;
  bit n_level = 0, n_pulse = 0;

  function automatic bit nth_bit(int w, int len, int pos);
    return ((w >>> (len - 1 - pos)) & 1) != 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit exp_valid, start, exp_tx;
    exp_valid = m_pend && !rx_off && !pwr_down;
    if (exp_valid) begin
      exp_word = m_pend_word;
      exp_sign = nth_bit(m_pend_word, m_pend_len, 0);
    end
    m_pend = 0;
    start = short_frame ? (m_cur_fall && !m_prev_fall) : (fsync && !m_prev_rise);
    if (pwr_down) m_active = 0;
    else if (start) begin
      m_lat = int'(tx_word);
      m_len = linear_mode ? LW : CW;
      m_pos = 0;
      m_active = 1;
    end else if (m_active) begin
      if (m_pos == m_len - 1) m_active = 0;
      else m_pos++;
    end
    if (pwr_down) exp_tx = 1;
    else exp_tx = m_active ? (nth_bit(m_lat, m_len, m_pos) && !tx_off) : 0;
    m_prev_rise = fsync;
    m_prev_fall = m_cur_fall;
    chk("tx_sd", int'(tx_sd), int'(exp_tx));
    chk("rx_valid", int'(rx_valid), int'(exp_valid));
    chk("rx_word", int'(rx_word), exp_word);
    chk("rx_sign", int'(rx_sign), int'(exp_sign));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    #1;
    fsync = n_level;
    m_cur_fall = n_level;
    if (m_active) begin
      rx_sd = nth_bit(rx_send, m_len, m_pos);
      if (m_pos == m_len - 1) begin
        m_pend = 1;
        m_pend_len = m_len;
        m_pend_word = rx_send & ((1 << m_len) - 1);
      end
    end else begin
      rx_sd = 1'b1;
    end
    if (n_pulse) begin
      #1 fsync = 1'b1;
      #2 fsync = 1'b0;
      m_cur_fall = 1;
    end
  endtask

  // pulse_style: 1 = high only across a falling edge; width = long-style cycles
  task automatic frame(bit sh, bit lin, bit pulse_style, int width,
                       int txw, int rxw, int change_at, int new_txw);
    short_frame = sh;
    linear_mode = lin;
    tx_word = LW'(txw);
    rx_send = rxw;
    if (pulse_style) n_pulse = 1; else n_level = 1;
    tick();
    n_pulse = 0;
    for (int i = 1; i < FRAME; i++) begin
      if (i >= width) n_level = 0;
      if (i == change_at) begin
        tx_word = LW'(new_txw);
        linear_mode = ~lin;
      end
      tick();
    end
    linear_mode = lin;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    fsync = 1'b1;
    tx_word = 14'h3FFF;
    repeat (2) @(posedge clk);
    #1;
    tag = "R1";
    chk("tx_sd", int'(tx_sd), 0);
    chk("rx_valid", int'(rx_valid), 0);
    chk("rx_word", int'(rx_word), 0);
    chk("rx_sign", int'(rx_sign), 0);
    #1;
    fsync = 1'b0;
    tx_word = '0;
    rst_n = 1'b1;
    repeat (3) tick();

    tag = "R2 R4 R6 R9 R11";
    frame(0, 0, 0, 3, 'hA5, 'h3C, -1, 0);
    frame(0, 0, 0, 1, 'h5A, 'h81, -1, 0);

    tag = "R2 R5 R9 R11";
    frame(0, 1, 0, 1, 'h2A5C, 'h3001, -1, 0);

    tag = "R3 R4 R9";
    frame(1, 0, 1, 1, 'hC3, 'h7E, -1, 0);
    tag = "R3 R5 R11";
    frame(1, 1, 1, 1, 'h1F0F, 'h2222, -1, 0);
    tag = "R3 held sync";
    frame(1, 0, 0, 4, 'h96, 'h69, -1, 0);

    tag = "R2 no start on falling-only pulse";
    frame(0, 0, 1, 1, 'hFF, 'hFF, -1, 0);

    tag = "R8";
    tx_off = 1'b1;
    frame(0, 0, 0, 1, 'hFF, 'h55, -1, 0);
    tx_off = 1'b0;

    tag = "R10";
    rx_off = 1'b1;
    frame(0, 1, 0, 1, 'h0AAA, 'h1234, -1, 0);
    rx_off = 1'b0;

    tag = "R7";
    pwr_down = 1'b1;
    frame(0, 0, 0, 1, 'hAA, 'hF0, -1, 0);
    pwr_down = 1'b0;
    repeat (4) tick();
    tag = "R7 R6 resume";
    frame(0, 0, 0, 1, 'h33, 'h0F, -1, 0);

    tag = "R12";
    frame(0, 1, 0, 1, 'h3C3C, 'h2BCD, 3, 'h0001);
    frame(1, 0, 1, 1, 'hE1, 'h80, 2, 'h1E);

    repeat (4) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule